// File: doc/BRIEF.md
# Command-Strobe Interval Timer Channel

This block is a single 32-bit interval timer channel behind a small register window. Software steers it with write-only command addresses: a write to the reset, start or stop address performs that action, and the data word that comes with it is discarded. Separate registers hold the counting mode, the terminal value and the interrupt enable. A read-only status word and a read-only live count let software observe the channel. Pending events are cleared through an acknowledge address.

The counter advances on clock cycles where the tick-enable input is high, and only while the channel runs. When it reaches the terminal value, an event is latched as pending. A level interrupt output is raised while the pending flag and the interrupt enable are both set. In continuous mode the count starts again from zero. In one-shot mode the channel halts at the terminal value and drops back to idle.

The bus port has a single cycle. Writes take effect on the next rising clock edge. Reads return data combinationally from the current register state.

Top module: `strobe_timer`

## Requirements
- R1: After the asynchronous reset, the following values hold:
  - Status reads 0x01: idle, stopped, continuous, interrupt disabled, nothing pending.
  - The count reads 0.
  - The terminal value reads 0xFFFFFFFF.
  - `irq_o` is low.
- R2: A write to byte offset 0x00 (reset), 0x04 (start) or 0x08 (stop) performs its command whatever the data value is. A stop or reset write in the same cycle as a tick keeps that tick from counting.
- R3: While the channel runs, the count read at offset 0x14 rises by exactly one for each cycle with `tick_i` high. While stopped it does not change.
- R4: A counted tick that brings the count equal to the terminal value (offset 0x18) sets pending. With a terminal value of 1, a single tick after start produces the event.
- R5: With mode bit 0 at 0 (continuous), the count returns to 0 at the terminal event and the channel keeps running.
- R6: With mode bit 0 at 1 (one-shot), the count holds at the terminal value at the event. The channel stops and the state field returns to idle.
- R7: A reset command clears the count and pending and leaves the channel stopped. The terminal value, the mode and the interrupt enable keep their values.
- R8: Status at offset 0x10 is laid out as follows:
  - Bits [3:0] hold 2 while running and 1 while stopped.
  - Bit 4 is the run flag.
  - Bit 5 is the one-shot mode.
  - Bit 6 is the interrupt enable.
  - Bit 7 is pending.
  - The upper bits read 0.
- R9: `irq_o` is high exactly when pending and interrupt enable (offset 0x1C, bit 0) are both set. Pending is still latched while the enable is 0.
- R10: A write to offset 0x20 with bit 7 set clears pending. Without bit 7 it has no effect. A terminal event in the same cycle wins, and pending stays set.
- R11: Reads of write-only offsets (0x00, 0x04, 0x08, 0x0C, 0x1C, 0x20) and of unmapped offsets return 0. The terminal value reads back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable for this cycle |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
A write or a counted tick is presented before a rising edge. Its effect on the count, the run flag, pending and the configuration registers is visible after that one edge. Read data and `irq_o` follow the registers with no further delay, so every result is due one cycle after its stimulus. The bench drives inputs at the falling edge. It advances its model by the same one edge, then reads status and count at the next falling edge and compares them together with `irq_o`. The corner cases called out in the requirements are directed: a terminal value of 1, an acknowledge colliding with an event, a stop colliding with a tick, and the one-shot halt. Random operation mixes cover the rest.

// File: rtl/strobe_timer_pkg.sv
package strobe_timer_pkg;
  localparam int unsigned OFS_RESET  = 'h00;
  localparam int unsigned OFS_START  = 'h04;
  localparam int unsigned OFS_STOP   = 'h08;
  localparam int unsigned OFS_MODE   = 'h0C;
  localparam int unsigned OFS_STATUS = 'h10;
  localparam int unsigned OFS_COUNT  = 'h14;
  localparam int unsigned OFS_TERM   = 'h18;
  localparam int unsigned OFS_IRQEN  = 'h1C;
  localparam int unsigned OFS_ACK    = 'h20;

  localparam int unsigned ACK_BIT = 7;

  typedef struct packed {
    logic rst;
    logic start;
    logic stop;
    logic mode;
    logic term;
    logic irqen;
    logic ack;
  } cmd_t;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd1,
    ST_ACTIVE = 4'd2
  } state_e;
endpackage

// File: rtl/strobe_timer_decode.sv
module strobe_timer_decode
  import strobe_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cmd_t              cmd_o
);
  always_comb begin
    cmd_o       = '0;
    cmd_o.rst   = we_i && (addr_i == ADDR_W'(OFS_RESET));
    cmd_o.start = we_i && (addr_i == ADDR_W'(OFS_START));
    cmd_o.stop  = we_i && (addr_i == ADDR_W'(OFS_STOP));
    cmd_o.mode  = we_i && (addr_i == ADDR_W'(OFS_MODE));
    cmd_o.term  = we_i && (addr_i == ADDR_W'(OFS_TERM));
    cmd_o.irqen = we_i && (addr_i == ADDR_W'(OFS_IRQEN));
    cmd_o.ack   = we_i && (addr_i == ADDR_W'(OFS_ACK));
  end
endmodule

// File: rtl/strobe_timer_cfg.sv
module strobe_timer_cfg
  import strobe_timer_pkg::*;
#(
  parameter int unsigned           DATA_W   = 32,
  parameter logic [DATA_W-1:0]     TERM_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_t              cmd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              oneshot_o,
  output logic              irqen_o,
  output logic [DATA_W-1:0] term_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oneshot_o <= 1'b0;
      irqen_o   <= 1'b0;
      term_o    <= TERM_RST;
    end else begin
      if (cmd_i.mode)  oneshot_o <= wdata_i[0];
      if (cmd_i.irqen) irqen_o   <= wdata_i[0];
      if (cmd_i.term)  term_o    <= wdata_i;
    end
  end

  // reset command must not disturb configuration
  assert_cfg_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.rst |=> ($stable(term_o) && $stable(oneshot_o) && $stable(irqen_o)));
endmodule

// File: rtl/strobe_timer_counter.sv
module strobe_timer_counter
  import strobe_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_t              cmd_i,
  input  logic              ack_bit_i,
  input  logic              tick_i,
  input  logic              oneshot_i,
  input  logic [DATA_W-1:0] term_i,
  output logic [DATA_W-1:0] count_o,
  output logic              run_o,
  output logic              pend_o
);
  logic              step;
  logic              hit;
  logic [DATA_W-1:0] count_inc;

  // stop/reset strobes win over a tick in the same cycle
  assign step      = run_o && tick_i && !cmd_i.stop && !cmd_i.rst;
  assign count_inc = count_o + DATA_W'(1);
  assign hit       = step && (count_inc == term_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      run_o   <= 1'b0;
      pend_o  <= 1'b0;
    end else if (cmd_i.rst) begin
      count_o <= '0;
      run_o   <= 1'b0;
      pend_o  <= 1'b0;
    end else begin
      if (step) count_o <= (hit && !oneshot_i) ? '0 : count_inc;

      if (cmd_i.start)             run_o <= 1'b1;
      else if (cmd_i.stop)         run_o <= 1'b0;
      else if (hit && oneshot_i)   run_o <= 1'b0;

      if (hit)                          pend_o <= 1'b1;
      else if (cmd_i.ack && ack_bit_i)  pend_o <= 1'b0;
    end
  end

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(run_o && tick_i) && !cmd_i.rst) |=> $stable(count_o));

  assert_event_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> pend_o);

  assert_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !oneshot_i && !cmd_i.stop) |=> (count_o == '0 && run_o));

  assert_oneshot_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && oneshot_i && !cmd_i.start) |=> (!run_o && count_o == $past(term_i)));

  assert_rst_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.rst |=> (count_o == '0 && !run_o && !pend_o));

  assert_ack_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.ack && ack_bit_i && !hit) |=> !pend_o);
endmodule

// File: rtl/strobe_timer_rdmux.sv
module strobe_timer_rdmux
  import strobe_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic [DATA_W-1:0] term_i,
  input  logic              run_i,
  input  logic              oneshot_i,
  input  logic              irqen_i,
  input  logic              pend_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned STAT_W = 8;

  state_e            state;
  logic [STAT_W-1:0] status;

  assign state  = run_i ? ST_ACTIVE : ST_IDLE;
  assign status = {pend_i, irqen_i, oneshot_i, run_i, state};

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_STATUS))     rdata_o = DATA_W'(status);
    else if (addr_i == ADDR_W'(OFS_COUNT)) rdata_o = count_i;
    else if (addr_i == ADDR_W'(OFS_TERM))  rdata_o = term_i;
  end
endmodule

// File: rtl/strobe_timer.sv
module strobe_timer
  import strobe_timer_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter int unsigned       DATA_W   = 32,
  parameter logic [DATA_W-1:0] TERM_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  cmd_t              cmd;
  logic              oneshot;
  logic              irqen;
  logic [DATA_W-1:0] term;
  logic [DATA_W-1:0] count;
  logic              run;
  logic              pend;

  strobe_timer_decode #(.ADDR_W(ADDR_W)) u_decode (
    .we_i   (we_i),
    .addr_i (addr_i),
    .cmd_o  (cmd)
  );

  strobe_timer_cfg #(.DATA_W(DATA_W), .TERM_RST(TERM_RST)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .wdata_i   (wdata_i),
    .oneshot_o (oneshot),
    .irqen_o   (irqen),
    .term_o    (term)
  );

  strobe_timer_counter #(.DATA_W(DATA_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .ack_bit_i (wdata_i[ACK_BIT]),
    .tick_i    (tick_i),
    .oneshot_i (oneshot),
    .term_i    (term),
    .count_o   (count),
    .run_o     (run),
    .pend_o    (pend)
  );

  strobe_timer_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
    .addr_i    (addr_i),
    .count_i   (count),
    .term_i    (term),
    .run_i     (run),
    .oneshot_i (oneshot),
    .irqen_i   (irqen),
    .pend_i    (pend),
    .rdata_o   (rdata_o)
  );

  assign irq_o = pend && irqen;

  assert_irq_needs_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd.irqen && !wdata_i[0]) |=> !irq_o);
endmodule

// File: tb/strobe_timer_tb_top.sv
module strobe_timer_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [7:0] A_RST = 8'h00, A_START = 8'h04, A_STOP = 8'h08,
                         A_MODE = 8'h0C, A_STAT = 8'h10, A_CNT = 8'h14,
                         A_TERM = 8'h18, A_IE = 8'h1C, A_ACK = 8'h20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  always #2.5 clk_i = ~clk_i;

  strobe_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_cnt = '0, m_term = '1;
  bit m_run = 0, m_pend = 0, m_os = 0, m_ie = 0;

  function automatic logic [31:0] exp_status();
    return {24'd0, m_pend, m_ie, m_os, m_run, (m_run ? 4'd2 : 4'd1)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    we_i = 0; tick_i = 0; addr_i = a;
    #0.2;
    d = rdata_o;
  endtask

  task automatic verify(string req);
    logic [31:0] d;
    rd(A_STAT, d); chk({req, " R8 status"}, d, exp_status());
    rd(A_CNT, d);  chk({req, " R3 count"}, d, m_cnt);
    chk({req, " R9 irq"}, {31'd0, irq_o}, {31'd0, m_pend & m_ie});
  endtask

  // drive one cycle and advance the model by one edge
  task automatic step(bit we, logic [7:0] a, logic [31:0] d, bit tk);
    logic [31:0] n_cnt, n_term;
    bit n_run, n_pend, n_os, n_ie, go, hit;
    we_i = we; addr_i = a; wdata_i = d; tick_i = tk;
    n_cnt = m_cnt; n_term = m_term; n_run = m_run; n_pend = m_pend;
    n_os = m_os; n_ie = m_ie;
    go  = m_run && tk && !(we && (a == A_STOP || a == A_RST));
    hit = go && (m_cnt + 32'd1 == m_term);
    if (we && a == A_RST) begin
      n_cnt = 0; n_run = 0; n_pend = 0;
    end else begin
      if (go) n_cnt = (hit && !m_os) ? 32'd0 : m_cnt + 32'd1;
      if (hit) begin
        n_pend = 1;
        if (m_os) n_run = 0;
      end
      if (we) begin
        case (a)
          A_START: n_run = 1;
          A_STOP:  n_run = 0;
          A_MODE:  n_os = d[0];
          A_TERM:  n_term = d;
          A_IE:    n_ie = d[0];
          A_ACK:   if (d[7] && !hit) n_pend = 0;
          default: ;
        endcase
      end
    end
    @(negedge clk_i);
    we_i = 0; tick_i = 0;
    m_cnt = n_cnt; m_term = n_term; m_run = n_run; m_pend = n_pend;
    m_os = n_os; m_ie = n_ie;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R3 watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] addrs [9] = '{A_RST, A_START, A_STOP, A_MODE, A_STAT,
                              A_CNT, A_TERM, A_IE, A_ACK};
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    verify("R1");
    rd(A_TERM, d); chk("R1 term", d, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R1 status", d, 32'h1);

    // R11 write-only reads zero even with state behind them
    step(1, A_MODE, 32'h1, 0);
    step(1, A_IE, 32'h1, 0);
    foreach (addrs[i]) begin
      if (addrs[i] inside {A_RST, A_START, A_STOP, A_MODE, A_IE, A_ACK}) begin
        rd(addrs[i], d); chk("R11 write-only", d, 32'h0);
      end
    end
    rd(8'h3C, d); chk("R11 unmapped", d, 32'h0);
    step(1, A_TERM, 32'h1234_5678, 0);
    rd(A_TERM, d); chk("R11 term readback", d, 32'h1234_5678);
    step(1, A_MODE, 32'h0, 0);
    step(1, A_IE, 32'h0, 0);
    verify("R8");

    // R4 terminal of 1, start with zero data (R2)
    step(1, A_TERM, 32'd1, 0);
    step(1, A_START, 32'h0, 0);
    verify("R2 start");
    step(0, A_STAT, 0, 1);
    verify("R4 single tick");
    chk("R5 wrap count", m_cnt, 32'd0);
    chk("R9 pending without irq", {31'd0, irq_o}, 32'd0);

    // R9 enable exposes pending
    step(1, A_IE, 32'h1, 0);
    verify("R9");

    // R10 ack without bit 7, then with
    step(1, A_ACK, 32'h7F, 0);
    verify("R10 no bit7");
    step(1, A_ACK, 32'h80, 0);
    verify("R10 ack");
    // collision: event wins
    step(1, A_ACK, 32'h80, 1);
    verify("R10 collision");
    step(1, A_ACK, 32'hFFFF_FF80, 0);

    // R2 stop with tick: no count
    step(1, A_TERM, 32'd10, 0);
    step(0, A_STAT, 0, 1);
    step(1, A_STOP, 32'hFFFF_FFFF, 1);
    verify("R2 stop beats tick");
    step(0, A_STAT, 0, 1);
    verify("R3 stopped hold");
    step(1, A_RST, 32'hDEAD_BEEF, 0);
    verify("R2 reset cmd");

    // R6 one-shot
    step(1, A_TERM, 32'd3, 0);
    step(1, A_MODE, 32'h1, 0);
    step(1, A_START, 32'h5, 0);
    repeat (3) step(0, A_STAT, 0, 1);
    verify("R6 oneshot halt");
    repeat (2) step(0, A_STAT, 0, 1);
    verify("R6 held");

    // R7 reset keeps config
    step(1, A_RST, 32'h0, 0);
    verify("R7");
    rd(A_TERM, d); chk("R7 term kept", d, 32'd3);

    // random mix
    for (int it = 0; it < 1500; it++) begin
      int r = $urandom_range(0, 99);
      int k = $urandom_range(0, 8);
      logic [31:0] dd = $urandom();
      bit tk = $urandom_range(0, 1);
      if (r < 55) step(0, A_STAT, 0, 1);
      else begin
        if (addrs[k] == A_TERM) dd = $urandom_range(1, 6);
        if (addrs[k] == A_RST && $urandom_range(0, 3) != 0) k = 1;
        step(1, addrs[k], dd, tk);
      end
      verify("R3 random");
      if (it % 50 == 0) begin
        rd(A_TERM, d); chk("R11 random term", d, m_term);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule